// File: doc/BRIEF.md
# Three-Slot Opcode Unpacker

This block sits between instruction memory and the execution datapath of a small stack processor. Each memory word carries up to three short opcodes packed side by side. The unpacker takes a whole word on its input stream and hands the opcodes one at a time to the datapath on its output stream, starting with the most significant field. A one-hot slot token walks across the three fields, one field per accepted opcode, so a single word keeps the datapath busy for several cycles while the next word is fetched.

The walk stops after the last field. It also stops early when the opcode just issued is a control transfer or a memory access (any opcode whose most significant bit is 0), because the fields after it are not meant to run. When the walk stops, a one-cycle done pulse tells the fetch side to supply the next word. Until then the input stream is held off.

Both sides are valid/ready streams. A word moves in on a cycle where `word_valid` and `word_ready` are both high. `word_ready` is low for as long as any slot of the current word is still pending, and `word_data` is ignored while it is low. An opcode moves out on a cycle where `op_valid` and `op_ready` are both high. While `op_ready` is low, the opcode and its slot indicator stay unchanged.

Top module: `opcode_unpacker`

## Requirements
- R1: While reset is asserted, and on the first cycle after reset, `op_valid` is 0, `word_done` is 0 and `word_ready` is 1. A reset in the middle of a word drops the rest of that word.
- R2: A word is accepted on a clock edge where `word_valid` and `word_ready` are both 1. On the next cycle `op_valid` is 1, `op_slot` is 3'b001 and `op_code` equals word bits 17:13.
- R3: After an opcode handshake that does not end the word, the following cycle presents the next field (bits 12:8 for slot 3'b010, then bits 7:3 for slot 3'b100), so there is one opcode per cycle while `op_ready` stays high. `op_slot` always has at most one bit set.
- R4: The handshake of the slot 3'b100 opcode ends the word. On the next cycle `op_valid` is 0 and `word_ready` is 1.
- R5: An issued opcode whose bit 4 is 0 (values 0 to 15: jumps, calls, returns, literal and memory fetches and stores) ends the word at its handshake. The later fields of that word are never presented.
- R6: Word bits 2:0 have no effect on any output.
- R7: While `op_valid` is 1, `word_ready` is 0. A word offered then is not taken, and the opcodes of the current word are unaffected by it.
- R8: While `op_valid` is 1 and `op_ready` is 0, `op_code` and `op_slot` hold their values into the next cycle.
- R9: `word_done` is 1 only in the cycle of the handshake that ends a word, and it is 0 at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| word_valid | input | 1 | Instruction word offered |
| word_ready | output | 1 | Unpacker can take a word (low while slots are pending) |
| word_data | input | 18 | Packed instruction word, slot 0 in bits 17:13 |
| op_valid | output | 1 | An opcode is presented |
| op_ready | input | 1 | Datapath takes the presented opcode |
| op_code | output | 5 | Presented opcode |
| op_slot | output | 3 | One-hot index of the presented field |
| word_done | output | 1 | Pulse: this handshake ends the current word |

## Verification
The assertions take for granted that `op_ready` is a plain level the datapath may lower at any time, and that `word_data` only needs to be meaningful on the cycle it is accepted. The stimulus drives every input on the falling edge, so no input changes near the sampling edge. It also offers new words while a word is still in flight and stalls the output stream in the middle of a word, so that hold-off and hold behaviour are exercised in a way the assertions can judge.

// File: rtl/opunpk_pkg.sv
package opunpk_pkg;
  localparam int DEF_WORD_W = 18;
  localparam int DEF_OP_W   = 5;
  localparam int DEF_SLOTS  = 3;

  // Lowest bit of field idx when fields are packed from the top of the word.
  function automatic int field_lsb(input int word_w, input int op_w, input int idx);
    return word_w - op_w * (idx + 1);
  endfunction
endpackage

// File: rtl/opunpk_word_reg.sv
module opunpk_word_reg #(
  parameter int FIELDS_W = 15
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [FIELDS_W-1:0] din,
  output logic [FIELDS_W-1:0] dout
);
  always_ff @(posedge clk) begin
    if (!rst_n)    dout <= '0;
    else if (load) dout <= din;
  end
endmodule

// File: rtl/opunpk_slot_ring.sv
module opunpk_slot_ring #(
  parameter int SLOTS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             advance,
  input  logic             stop,
  output logic [SLOTS-1:0] slot_q,
  output logic             last
);
  localparam logic [SLOTS-1:0] FIRST = {{(SLOTS-1){1'b0}}, 1'b1};

  assign last = advance && (stop || slot_q[SLOTS-1]);

  always_ff @(posedge clk) begin
    if (!rst_n)        slot_q <= '0;
    else if (load)     slot_q <= FIRST;
    else if (advance) begin
      if (last)        slot_q <= '0;
      else             slot_q <= slot_q << 1;
    end
  end

  assert_token_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(slot_q));

  assert_token_walks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !stop && !slot_q[SLOTS-1]) |=> (slot_q == ($past(slot_q) << 1)));

  assert_token_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && slot_q[SLOTS-1]) |=> (slot_q == '0));
endmodule

// File: rtl/opunpk_field_sel.sv
module opunpk_field_sel #(
  parameter int OP_W  = 5,
  parameter int SLOTS = 3
) (
  input  logic [SLOTS*OP_W-1:0] fields,
  input  logic [SLOTS-1:0]      slot,
  output logic [OP_W-1:0]       op
);
  logic [OP_W-1:0] part [SLOTS];

  for (genvar i = 0; i < SLOTS; i++) begin : g_field
    localparam int LSB = opunpk_pkg::field_lsb(SLOTS*OP_W, OP_W, i);
    assign part[i] = {OP_W{slot[i]}} & fields[LSB +: OP_W];
  end

  always_comb begin
    op = '0;
    for (int i = 0; i < SLOTS; i++) op = op | part[i];
  end
endmodule

// File: rtl/opcode_unpacker.sv
module opcode_unpacker #(
  parameter int WORD_W = opunpk_pkg::DEF_WORD_W,
  parameter int OP_W   = opunpk_pkg::DEF_OP_W,
  parameter int SLOTS  = opunpk_pkg::DEF_SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  output logic              word_ready,
  input  logic [WORD_W-1:0] word_data,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [OP_W-1:0]   op_code,
  output logic [SLOTS-1:0]  op_slot,
  output logic              word_done
);
  localparam int FIELDS_W = SLOTS * OP_W;
  localparam int PAD_W    = WORD_W - FIELDS_W;

  logic [FIELDS_W-1:0] fields_q;
  logic                load;
  logic                fire;
  logic                ends_early;

  if (PAD_W > 0) begin : g_pad
    logic unused_pad;
    assign unused_pad = ^word_data[PAD_W-1:0];
  end

  assign word_ready = ~op_valid;
  assign load       = word_valid && word_ready;
  assign fire       = op_valid && op_ready;
  assign ends_early = ~op_code[OP_W-1];

  opunpk_word_reg #(.FIELDS_W(FIELDS_W)) u_word (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .din   (word_data[WORD_W-1 -: FIELDS_W]),
    .dout  (fields_q)
  );

  opunpk_slot_ring #(.SLOTS(SLOTS)) u_ring (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .advance (fire),
    .stop    (ends_early),
    .slot_q  (op_slot),
    .last    (word_done)
  );

  opunpk_field_sel #(.OP_W(OP_W), .SLOTS(SLOTS)) u_sel (
    .fields (fields_q),
    .slot   (op_slot),
    .op     (op_code)
  );

  assign op_valid = |op_slot;

  assert_first_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && word_ready) |=>
      (op_valid && op_slot == 1 && op_code == $past(word_data[WORD_W-1 -: OP_W])));

  assert_busy_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !word_ready);

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_code) && $stable(op_slot)));

  assert_done_on_fire_R9: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> (op_valid && op_ready));

  assert_done_then_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> (!op_valid && word_ready));

  assert_early_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_ready && !op_code[OP_W-1]) |-> word_done);

  always_comb begin
    if (!op_valid) assert_idle_quiet_R9: assert (!word_done);
  end
endmodule

// File: tb/opcode_unpacker_test.sv
module opcode_unpacker_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        word_valid = 1'b0;
  logic        word_ready;
  logic [17:0] word_data = '0;
  logic        op_valid;
  logic        op_ready = 1'b1;
  logic [4:0]  op_code;
  logic [2:0]  op_slot;
  logic        word_done;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  opcode_unpacker uut (
    .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_ready(word_ready),
    .word_data(word_data), .op_valid(op_valid), .op_ready(op_ready),
    .op_code(op_code), .op_slot(op_slot), .word_done(word_done)
  );

  // Vector table: packed word and the number of opcodes it should issue.
  localparam int NV = 7;
  localparam logic [17:0] VW [NV] = '{
    {5'h1E, 5'h17, 5'h10, 3'b000},
    {5'h02, 5'h1E, 5'h1E, 3'b000},
    {5'h17, 5'h0B, 5'h1E, 3'b111},
    {5'h11, 5'h15, 5'h06, 3'b101},
    {5'h00, 5'h1F, 5'h1F, 3'b010},
    {5'h1F, 5'h1F, 5'h1F, 3'b111},
    {5'h1A, 5'h1C, 5'h09, 3'b000}
  };
  localparam int VN [NV] = '{3, 1, 2, 3, 1, 3, 3};
  localparam string VT [NV] = '{"R3", "R5", "R5", "R4", "R5", "R6", "R3"};

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_word(input logic [17:0] w, input int n, input string tag);
    @(negedge clk);
    check(word_ready == 1'b1, tag, word_ready, 1);
    word_valid = 1'b1;
    word_data  = w;
    @(negedge clk);
    word_valid = 1'b0;
    word_data  = '0;
    for (int i = 0; i < 3; i++) begin
      if (i < n) begin
        check(op_valid == 1'b1, tag, op_valid, 1);
        check(op_code == w[17-5*i -: 5], tag, op_code, w[17-5*i -: 5]);
        check(op_slot == 3'(1 << i), tag, op_slot, 3'(1 << i));
        check(word_done == (i == n-1), tag, word_done, (i == n-1));
        @(negedge clk);
      end
    end
    check(op_valid == 1'b0, "R4", op_valid, 0);
    check(word_ready == 1'b1, "R4", word_ready, 1);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [4:0] held;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(op_valid == 1'b0, "R1", op_valid, 0);
    check(word_done == 1'b0, "R1", word_done, 0);
    check(word_ready == 1'b1, "R1", word_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(op_valid == 1'b0, "R1", op_valid, 0);
    check(word_ready == 1'b1, "R1", word_ready, 1);

    // Table walk with the datapath always ready (R2, R3, R4, R5, R6)
    for (int v = 0; v < NV; v++) run_word(VW[v], VN[v], VT[v]);

    // R6: pad bits only differ; same opcodes expected
    run_word({5'h13, 5'h14, 5'h12, 3'b000}, 3, "R6");
    run_word({5'h13, 5'h14, 5'h12, 3'b110}, 3, "R6");

    // R7 and R8: stall output, offer a second word while busy
    @(negedge clk);
    op_ready   = 1'b0;
    word_valid = 1'b1;
    word_data  = {5'h17, 5'h1E, 5'h02, 3'b000};
    @(negedge clk);
    word_data  = {5'h00, 5'h00, 5'h00, 3'b000};
    check(op_valid == 1'b1 && op_code == 5'h17, "R2", op_code, 5'h17);
    check(word_ready == 1'b0, "R7", word_ready, 0);
    held = op_code;
    @(negedge clk);
    check(op_code == held && op_slot == 3'b001, "R8", op_code, held);
    check(op_valid == 1'b1, "R8", op_valid, 1);
    check(word_done == 1'b0, "R9", word_done, 0);
    op_ready = 1'b1;
    @(negedge clk);
    check(op_code == 5'h1E && op_slot == 3'b010, "R7", op_code, 5'h1E);
    @(negedge clk);
    check(op_code == 5'h02 && op_slot == 3'b100, "R7", op_code, 5'h02);
    check(word_done == 1'b1, "R9", word_done, 1);
    check(word_ready == 1'b0, "R7", word_ready, 0);
    @(negedge clk);
    word_valid = 1'b0;
    check(op_valid == 1'b0 && word_ready == 1'b1, "R4", op_valid, 0);
    @(negedge clk);
    check(op_valid == 1'b0, "R7", op_valid, 0);

    // R1: reset in the middle of a word drops the rest
    word_valid = 1'b1;
    word_data  = {5'h1E, 5'h1E, 5'h1E, 3'b000};
    @(negedge clk);
    word_valid = 1'b0;
    check(op_valid == 1'b1, "R2", op_valid, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(op_valid == 1'b0 && word_done == 1'b0, "R1", op_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(op_valid == 1'b0 && word_ready == 1'b1, "R1", op_valid, 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule